// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block performs the hardware side of taking an interrupt, and of coming back from one, in a segmented 16-bit processor. It holds the code segment, instruction pointer, stack segment, stack pointer and flag word. It watches four request sources: an exception request carrying its own vector number and an optional error code, a nonmaskable line, a maskable line, and an interrupt-return command. When a request is accepted, the block saves state to the stack, one 16-bit word per cycle. Between the flag-word push and the code-segment push it clears the interrupt-enable and trap bits. It then reads the handler address from a 256-entry table of 32-bit entries.

An interrupt-return pops the saved words back into the registers and execution resumes at the restored code segment and instruction pointer. Stack memory is a single port with combinational read data. The vector table is a separate read port, also with combinational read data. The instruction datapath and the handler code are outside the block.

Top module: `irq_seq`

## Requirements
- R1: After reset the registers hold their reset parameters, busy is low, and no stack or vector access is made.
- R2: Entry makes one stack write per cycle. The words go in this order: SS, the SP value at acceptance (SP0), FLAGS, CS, IP. They go to SP0-2, SP0-4, SP0-6, SP0-8 and SP0-10 in the stack segment. The stack address is SS*16 + offset, and SP drops by 2 with each write.
- R3: The FLAGS word written to the stack is the value before entry. After the FLAGS push and before the CS push there is one cycle with no write, and in it bit 9 (interrupt enable) and bit 8 (trap) are cleared. All other flag bits are unchanged.
- R4: The last entry cycle reads table byte address 4n, where n is the vector. The low half of the entry goes to IP and the high half to CS. The vector is exc_vec for an exception, the parameter NMI_VEC (2) for the nonmaskable line, and int_vec for the maskable line.
- R5: While bit 9 of FLAGS is 0, a maskable request is ignored: no stack write, no busy, and no register change.
- R6: A nonmaskable request is accepted whatever bit 9 of FLAGS holds.
- R7: Requests are sampled only while idle. The priority is exception, then nonmaskable, then maskable, then return. A request that is raised and dropped during a sequence has no effect.
- R8: An exception with exc_err_en set writes exc_err as a sixth word at SP0-12, after IP, and leaves SP at SP0-12. Without an error code, SP ends at SP0-10.
- R9: A return reads IP, CS, FLAGS, SP and SS, in that order, from consecutive rising stack addresses starting at the current SP. Each register takes its popped value, and SP ends at the popped SP.
- R10: busy is high for exactly 7 cycles on entry, 8 with an error code, and 5 on return. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq | input | 1 | Maskable interrupt request (level) |
| int_vec | input | 8 | Vector number for the maskable request |
| nmreq | input | 1 | Nonmaskable interrupt request (level) |
| exc_req | input | 1 | Exception request |
| exc_vec | input | 8 | Exception vector number |
| exc_err_en | input | 1 | Exception carries an error code |
| exc_err | input | 16 | Error code word |
| ret_req | input | 1 | Interrupt-return command |
| stk_wr | output | 1 | Stack write strobe |
| stk_rd | output | 1 | Stack read strobe |
| stk_addr | output | 20 | Stack physical byte address |
| stk_wdata | output | 16 | Stack write data |
| stk_rdata | input | 16 | Stack read data (same cycle) |
| vt_rd | output | 1 | Vector table read strobe |
| vt_addr | output | 10 | Vector table byte address |
| vt_rdata | input | 32 | Vector table entry (same cycle) |
| cs | output | 16 | Code segment register |
| ip | output | 16 | Instruction pointer register |
| ss | output | 16 | Stack segment register |
| sp | output | 16 | Stack pointer register |
| flags | output | 16 | Flag word register |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
The bench builds the block with SS=0x0100, SP=0x0080, CS=0x1234, IP=0x5678 and a reset flag word of 0x0302. Because that flag word has both interrupt enable and trap set, the clearing of each bit is visible. Because the stack sits in a 512-byte window, a nested entry (an exception on top of a nonmaskable entry) and two returns in a row can be traced word by word. NMI_VEC stays at 2, and the table model returns an entry built from the vector number. This means every CS:IP load shows whether the right vector and the right address were used.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    parameter int unsigned WORD_W = 16;
    parameter int unsigned VEC_W  = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_PSS, S_PSP, S_PFL, S_CLR, S_PCS, S_PIP, S_PERR, S_VEC,
        S_RIP, S_RCS, S_RFL, S_RSP, S_RSS
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [WORD_W-1:0]   cs;
        logic [WORD_W-1:0]   ip;
        logic [WORD_W-1:0]   ss;
        logic [WORD_W-1:0]   sp;
        logic [WORD_W-1:0]   fl;
        logic [WORD_W-1:0]   hold;
        logic [WORD_W-1:0]   err;
        logic [VEC_W-1:0]    vec;
        logic                has_err;
    } seq_regs_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_seq_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'd2
) (
    input  logic             mreq,
    input  logic             if_en,
    input  logic [VEC_W-1:0] int_vec,
    input  logic             nmreq,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             exc_err_en,
    input  logic             ret_req,
    output logic             take,
    output logic             is_ret,
    output logic [VEC_W-1:0] vec,
    output logic             has_err
);
    logic mask_ok;

    always_comb begin
        mask_ok = mreq && if_en;
        take    = exc_req || nmreq || mask_ok;
        is_ret  = ret_req && !take;
        has_err = exc_req && exc_err_en;
        if (exc_req)    vec = exc_vec;
        else if (nmreq) vec = NMI_VEC;
        else            vec = int_vec;
    end
endmodule

// File: rtl/irq_seg_addr.sv
module irq_seg_addr #(
    parameter int unsigned W     = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned AW   = W + SHIFT
) (
    input  logic [W-1:0]  seg,
    input  logic [W-1:0]  off,
    output logic [AW-1:0] phys
);
    assign phys = {seg, {SHIFT{1'b0}}} + AW'(off);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned       SEG_SHIFT = 4,
    parameter int unsigned       IF_BIT    = 9,
    parameter int unsigned       TF_BIT    = 8,
    parameter logic [VEC_W-1:0]  NMI_VEC   = 8'd2,
    parameter logic [WORD_W-1:0] RST_CS    = 16'hF000,
    parameter logic [WORD_W-1:0] RST_IP    = 16'h0000,
    parameter logic [WORD_W-1:0] RST_SS    = 16'h0000,
    parameter logic [WORD_W-1:0] RST_SP    = 16'h0400,
    parameter logic [WORD_W-1:0] RST_FL    = 16'h0202,
    localparam int unsigned ST_AW = WORD_W + SEG_SHIFT,
    localparam int unsigned VT_AW = VEC_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mreq,
    input  logic [VEC_W-1:0]    int_vec,
    input  logic                nmreq,
    input  logic                exc_req,
    input  logic [VEC_W-1:0]    exc_vec,
    input  logic                exc_err_en,
    input  logic [WORD_W-1:0]   exc_err,
    input  logic                ret_req,
    output logic                stk_wr,
    output logic                stk_rd,
    output logic [ST_AW-1:0]    stk_addr,
    output logic [WORD_W-1:0]   stk_wdata,
    input  logic [WORD_W-1:0]   stk_rdata,
    output logic                vt_rd,
    output logic [VT_AW-1:0]    vt_addr,
    input  logic [2*WORD_W-1:0] vt_rdata,
    output logic [WORD_W-1:0]   cs,
    output logic [WORD_W-1:0]   ip,
    output logic [WORD_W-1:0]   ss,
    output logic [WORD_W-1:0]   sp,
    output logic [WORD_W-1:0]   flags,
    output logic                busy
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    seq_regs_t r_q, r_d;

    logic             take, is_ret, pick_err;
    logic [VEC_W-1:0] pick_vec;
    logic [WORD_W-1:0] sp_dn, sp_up, stk_off;
    logic             pushing;

    irq_pick #(.NMI_VEC(NMI_VEC)) u_pick (
        .mreq      (mreq),
        .if_en     (r_q.fl[IF_BIT]),
        .int_vec   (int_vec),
        .nmreq     (nmreq),
        .exc_req   (exc_req),
        .exc_vec   (exc_vec),
        .exc_err_en(exc_err_en),
        .ret_req   (ret_req),
        .take      (take),
        .is_ret    (is_ret),
        .vec       (pick_vec),
        .has_err   (pick_err)
    );

    assign sp_dn   = r_q.sp - STEP;
    assign sp_up   = r_q.sp + STEP;
    assign pushing = r_q.st inside {S_PSS, S_PSP, S_PFL, S_PCS, S_PIP, S_PERR};
    assign stk_off = pushing ? sp_dn : r_q.sp;

    irq_seg_addr #(.W(WORD_W), .SHIFT(SEG_SHIFT)) u_stk_addr (
        .seg (r_q.ss),
        .off (stk_off),
        .phys(stk_addr)
    );

    always_comb begin
        r_d       = r_q;
        stk_wr    = pushing;
        stk_rd    = 1'b0;
        stk_wdata = '0;
        vt_rd     = 1'b0;
        if (pushing) r_d.sp = sp_dn;
        unique case (r_q.st)
            S_IDLE: begin
                if (take) begin
                    r_d.st      = S_PSS;
                    r_d.hold    = r_q.sp;
                    r_d.vec     = pick_vec;
                    r_d.has_err = pick_err;
                    r_d.err     = exc_err;
                end else if (is_ret) begin
                    r_d.st = S_RIP;
                end
            end
            S_PSS: begin stk_wdata = r_q.ss;   r_d.st = S_PSP; end
            S_PSP: begin stk_wdata = r_q.hold; r_d.st = S_PFL; end
            S_PFL: begin stk_wdata = r_q.fl;   r_d.st = S_CLR; end
            S_CLR: begin
                r_d.fl[IF_BIT] = 1'b0;
                r_d.fl[TF_BIT] = 1'b0;
                r_d.st         = S_PCS;
            end
            S_PCS: begin stk_wdata = r_q.cs; r_d.st = S_PIP; end
            S_PIP: begin
                stk_wdata = r_q.ip;
                r_d.st    = r_q.has_err ? S_PERR : S_VEC;
            end
            S_PERR: begin stk_wdata = r_q.err; r_d.st = S_VEC; end
            S_VEC: begin
                vt_rd  = 1'b1;
                r_d.ip = vt_rdata[WORD_W-1:0];
                r_d.cs = vt_rdata[2*WORD_W-1:WORD_W];
                r_d.st = S_IDLE;
            end
            S_RIP: begin stk_rd = 1'b1; r_d.ip = stk_rdata; r_d.sp = sp_up; r_d.st = S_RCS; end
            S_RCS: begin stk_rd = 1'b1; r_d.cs = stk_rdata; r_d.sp = sp_up; r_d.st = S_RFL; end
            S_RFL: begin stk_rd = 1'b1; r_d.fl = stk_rdata; r_d.sp = sp_up; r_d.st = S_RSP; end
            S_RSP: begin stk_rd = 1'b1; r_d.hold = stk_rdata; r_d.sp = sp_up; r_d.st = S_RSS; end
            S_RSS: begin
                stk_rd = 1'b1;
                r_d.ss = stk_rdata;
                r_d.sp = r_q.hold;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, cs: RST_CS, ip: RST_IP, ss: RST_SS, sp: RST_SP,
                     fl: RST_FL, hold: '0, err: '0, vec: '0, has_err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign vt_addr = {r_q.vec, 2'b00};
    assign cs      = r_q.cs;
    assign ip      = r_q.ip;
    assign ss      = r_q.ss;
    assign sp      = r_q.sp;
    assign flags   = r_q.fl;
    assign busy    = (r_q.st != S_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int unsigned IF_BIT = 9,
    parameter int unsigned TF_BIT = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mreq,
    input logic        nmreq,
    input logic        exc_req,
    input logic        ret_req,
    input logic        stk_wr,
    input logic        stk_rd,
    input logic        vt_rd,
    input logic [9:0]  vt_addr,
    input logic [15:0] sp,
    input logic [15:0] flags,
    input logic        busy
);
    p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_wr && stk_rd) && !(vt_rd && (stk_wr || stk_rd)));

    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stk_wr |=> (sp == 16'($past(sp) - 16'd2)));

    p_flags_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vt_rd |-> (!flags[IF_BIT] && !flags[TF_BIT]));

    p_vec_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vt_rd |-> (vt_addr[1:0] == 2'b00));

    p_mask_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mreq && !flags[IF_BIT] && !nmreq && !exc_req && !ret_req) |=> !busy);

    p_nmi_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && nmreq) |=> (busy && stk_wr));

    p_access_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr || stk_rd || vt_rd) |-> busy);
endmodule

bind irq_seq irq_seq_chk #(.IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .mreq(mreq), .nmreq(nmreq), .exc_req(exc_req),
    .ret_req(ret_req), .stk_wr(stk_wr), .stk_rd(stk_rd), .vt_rd(vt_rd),
    .vt_addr(vt_addr), .sp(sp), .flags(flags), .busy(busy)
);

// File: tb/tb_irq_seq.sv
module tb_irq_seq;
    localparam time CLK_T = 10ns;
    localparam logic [15:0] SS0 = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreq = 0, nmreq = 0, exc_req = 0, exc_err_en = 0, ret_req = 0;
    logic [7:0]  int_vec = 0, exc_vec = 0;
    logic [15:0] exc_err = 0;
    logic        stk_wr, stk_rd, vt_rd, busy;
    logic [19:0] stk_addr;
    logic [15:0] stk_wdata, stk_rdata, cs, ip, ss, sp, flags;
    logic [9:0]  vt_addr;
    logic [31:0] vt_rdata;

    int total = 0, bad = 0;
    logic [15:0] smem [0:255];
    logic [19:0] wa [0:15];
    logic [15:0] wd [0:15];
    int nw = 0, nbusy = 0;

    always #(CLK_T/2) clk = ~clk;

    irq_seq #(.RST_CS(16'h1234), .RST_IP(16'h5678), .RST_SS(SS0),
              .RST_SP(16'h0080), .RST_FL(16'h0302)) dut (
        .clk(clk), .rst_n(rst_n), .mreq(mreq), .int_vec(int_vec), .nmreq(nmreq),
        .exc_req(exc_req), .exc_vec(exc_vec), .exc_err_en(exc_err_en),
        .exc_err(exc_err), .ret_req(ret_req), .stk_wr(stk_wr), .stk_rd(stk_rd),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
        .vt_rd(vt_rd), .vt_addr(vt_addr), .vt_rdata(vt_rdata), .cs(cs), .ip(ip),
        .ss(ss), .sp(sp), .flags(flags), .busy(busy)
    );

    assign stk_rdata = smem[stk_addr[8:1]];
    assign vt_rdata  = {8'hC0, vt_addr[9:2], 8'h10, vt_addr[9:2]};

    always @(posedge clk) if (stk_wr) smem[stk_addr[8:1]] <= stk_wdata;

    always @(negedge clk) begin
        if (busy) nbusy++;
        if (stk_wr && nw < 16) begin wa[nw] = stk_addr; wd[nw] = stk_wdata; end
        if (stk_wr) nw++;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0; nbusy = 0;
    endtask

    task automatic finish_seq();
        @(posedge clk);
        @(negedge clk);
        mreq = 0; nmreq = 0; exc_req = 0; exc_err_en = 0; ret_req = 0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        #1;
    endtask

    task automatic check_entry(string tag, logic [15:0] sp0, logic [15:0] fl0,
                               logic [15:0] cs0, logic [15:0] ip0, logic [7:0] vec,
                               bit has_err, logic [15:0] err);
        logic [15:0] exp_d [0:5];
        int n = has_err ? 6 : 5;
        exp_d[0] = SS0; exp_d[1] = sp0; exp_d[2] = fl0;
        exp_d[3] = cs0; exp_d[4] = ip0; exp_d[5] = err;
        chk("R2", {tag, " write count"}, nw, n);
        for (int k = 0; k < n && k < nw; k++) begin
            chk("R2", {tag, " push addr"}, wa[k], {SS0, 4'h0} + 20'(sp0 - 16'(2*(k+1))));
            chk(k == 2 ? "R3" : (k == 5 ? "R8" : "R2"), {tag, " push data"}, wd[k], exp_d[k]);
        end
        chk("R8", {tag, " final sp"}, sp, 16'(sp0 - 16'(2*n)));
        chk("R3", {tag, " flags after"}, flags, fl0 & 16'hFCFF);
        chk("R4", {tag, " cs"}, cs, {8'hC0, vec});
        chk("R4", {tag, " ip"}, ip, {8'h10, vec});
        chk("R2", {tag, " ss kept"}, ss, SS0);
        chk("R10", {tag, " busy cycles"}, nbusy, 7 + (has_err ? 1 : 0));
    endtask

    task automatic check_ret(string tag, logic [15:0] e_ip, logic [15:0] e_cs,
                             logic [15:0] e_fl, logic [15:0] e_sp);
        chk("R9", {tag, " ip"}, ip, e_ip);
        chk("R9", {tag, " cs"}, cs, e_cs);
        chk("R9", {tag, " flags"}, flags, e_fl);
        chk("R9", {tag, " sp"}, sp, e_sp);
        chk("R9", {tag, " ss"}, ss, SS0);
        chk("R9", {tag, " no writes"}, nw, 0);
        chk("R10", {tag, " busy cycles"}, nbusy, 5);
    endtask

    task automatic t_reset();
        chk("R1", "cs", cs, 16'h1234);
        chk("R1", "ip", ip, 16'h5678);
        chk("R1", "ss", ss, SS0);
        chk("R1", "sp", sp, 16'h0080);
        chk("R1", "flags", flags, 16'h0302);
        chk("R1", "busy", busy, 0);
        chk("R1", "ports", {stk_wr, stk_rd, vt_rd}, 0);
    endtask

    // R6 R7: nonmaskable beats maskable when both rise together
    task automatic t_nmi_over_mask();
        clear_log();
        @(negedge clk); mreq = 1; int_vec = 8'h21; nmreq = 1;
        finish_seq();
        check_entry("R7 nmi+mask", 16'h0080, 16'h0302, 16'h1234, 16'h5678, 8'd2, 0, 0);
    endtask

    // R5: maskable ignored with IF clear
    task automatic t_mask_blocked();
        clear_log();
        @(negedge clk); mreq = 1; int_vec = 8'h33;
        repeat (5) @(negedge clk);
        mreq = 0;
        @(negedge clk); #1;
        chk("R5", "no writes", nw, 0);
        chk("R5", "no busy", nbusy, 0);
        chk("R5", "cs kept", cs, 16'hC002);
        chk("R5", "sp kept", sp, 16'h0076);
    endtask

    // R7: exception beats nonmaskable; nested entry
    task automatic t_exc_over_nmi();
        clear_log();
        @(negedge clk); exc_req = 1; exc_vec = 8'd0; nmreq = 1;
        finish_seq();
        check_entry("R7 exc+nmi", 16'h0076, 16'h0002, 16'hC002, 16'h1002, 8'd0, 0, 0);
    endtask

    task automatic t_return(string tag, logic [15:0] e_ip, logic [15:0] e_cs,
                            logic [15:0] e_fl, logic [15:0] e_sp);
        clear_log();
        @(negedge clk); ret_req = 1;
        finish_seq();
        check_ret(tag, e_ip, e_cs, e_fl, e_sp);
    endtask

    // R5 R4: maskable accepted with IF set, vector from int_vec
    task automatic t_mask_taken();
        clear_log();
        @(negedge clk); mreq = 1; int_vec = 8'h21;
        finish_seq();
        check_entry("R5 mask", 16'h0080, 16'h0302, 16'h1234, 16'h5678, 8'h21, 0, 0);
    endtask

    // R8 R7: exception with error code; nmi pulse mid-sequence ignored
    task automatic t_exc_err();
        clear_log();
        @(negedge clk); exc_req = 1; exc_vec = 8'd12; exc_err_en = 1; exc_err = 16'hBEEF;
        @(posedge clk);
        @(negedge clk);
        exc_req = 0; exc_err_en = 0;
        @(negedge clk); nmreq = 1;
        @(negedge clk); nmreq = 0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        #1;
        check_entry("R8 exc err", 16'h0080, 16'h0302, 16'h1234, 16'h5678, 8'd12, 1, 16'hBEEF);
        clear_log();
        repeat (3) @(negedge clk);
        #1;
        chk("R7", "pulse during busy dropped", nbusy, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) smem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_nmi_over_mask();
        t_mask_blocked();
        t_exc_over_nmi();
        t_return("R9 ret1", 16'h1002, 16'hC002, 16'h0002, 16'h0076);
        t_return("R9 ret2", 16'h5678, 16'h1234, 16'h0302, 16'h0080);
        t_mask_taken();
        t_return("R9 ret3", 16'h5678, 16'h1234, 16'h0302, 16'h0080);
        t_exc_err();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule